// File: doc/BRIEF.md
# Serial Flash Status Register Emulator

This block models the multi-byte status register of a serial flash device as seen from an SPI host. It runs on a fast core clock and oversamples the SPI lines (SCK, chip select, MOSI), working in SPI mode 0. It listens for the opcode byte at the start of each transaction. When the opcode matches one of the configurable read-status opcodes, the block drives the chosen status byte on MISO. It keeps sending that byte until chip select goes high.

The register has two copies, a staged one and a committed one. Software write requests, the busy strobe from the command-upload path, and the write-enable and write-disable opcodes all change the staged copy. The committed copy is what the host reads and what software sees. It takes the staged value at two points: when chip select is released, and at the end of every byte (every eighth SCK rising edge) inside a transaction. Because of this, a single read-status transaction can poll BUSY and see it change between bytes. A passthrough block signal follows BUSY, but it only updates when chip select is released.

Top module: `stsreg_emu`

## Requirements
- R1: After reset, the committed status is all zero, the MISO output enable is low and the passthrough block signal is low.
- R2: Read-status opcode slot i is `cfg_rdsr_ops[8i+7:8i]`. Sending it makes the block return committed status byte i (`status_committed[8i+7:8i]`) on MISO, MSB first. Each bit changes after a falling SCK edge and the output enable is high. If two slots hold the same opcode, the lowest slot index wins.
- R3: After a read-status opcode, every following byte returns the targeted status byte. It is re-sampled from the committed register at each byte boundary, until chip select rises.
- R4: Software writes and hardware events change only the staged copy. The committed copy takes the staged value only at chip-select release, and at each eighth SCK rising edge while chip select is low.
- R5: A software write sets every bit except BUSY (byte 0 bit 0) and WEL (byte 0 bit 1). For those two bits, a written 0 clears the bit and a written 1 has no effect.
- R6: A pulse on `upload_busy` sets BUSY. If a software clear of BUSY falls in the same commit window as the pulse, BUSY stays set.
- R7: The write-enable opcode (`cfg_wren_op`) sets WEL at the end of the opcode byte. The write-disable opcode (`cfg_wrdi_op`) clears WEL at the same point.
- R8: `passthru_block` changes only when chip select is released. At that point it takes the value of BUSY that is being committed.
- R9: Releasing chip select does not reset the status register. An opcode that matches no read-status slot leaves the MISO output enable low.
- R10: The committed status holds its value in every cycle that is not a commit point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock used to oversample the SPI lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host-to-device serial data |
| spi_miso | output | 1 | Device-to-host serial data |
| spi_miso_oe | output | 1 | Output enable for MISO |
| cfg_rdsr_ops | input | 24 | Read-status opcodes; slot i selects status byte i |
| cfg_wren_op | input | 8 | Write-enable opcode |
| cfg_wrdi_op | input | 8 | Write-disable opcode |
| upload_busy | input | 1 | Strobe: an uploaded command has its busy attribute set |
| sw_wr_valid | input | 1 | Software write request strobe |
| sw_wr_data | input | 24 | Software write value |
| status_committed | output | 24 | Committed status register |
| passthru_block | output | 1 | Passthrough block signal, follows committed BUSY |

## Verification
The bench uses the default configuration: three status bytes of eight bits each. With this configuration, every readout slot can be swept through every opcode. A byte boundary, and with it a mid-transaction commit, comes every eight SCK edges. Four-byte polling transactions are therefore short enough to inject a software write or a busy strobe at a chosen byte and watch it appear one byte later. Duplicate opcodes across slots, and software writes that try to set BUSY or WEL, are exercised against the same arithmetic model.

// File: rtl/stsreg_pkg.sv
package stsreg_pkg;
  localparam int unsigned STS_BYTES  = 3;
  localparam int unsigned STS_BYTE_W = 8;
  localparam int unsigned BUSY_BIT   = 0;
  localparam int unsigned WEL_BIT    = 1;
endpackage

// File: rtl/stsreg_spi_front.sv
module stsreg_spi_front (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic csn,
  input  logic mosi,
  output logic csn_q,
  output logic mosi_q,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise
);
  logic sck_q, sck_p, csn_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      sck_p  <= 1'b0;
      csn_q  <= 1'b1;
      csn_p  <= 1'b1;
      mosi_q <= 1'b0;
    end else begin
      sck_q  <= sck;
      sck_p  <= sck_q;
      csn_q  <= csn;
      csn_p  <= csn_q;
      mosi_q <= mosi;
    end
  end

  assign sck_rise = sck_q & ~sck_p & ~csn_q;
  assign sck_fall = ~sck_q & sck_p & ~csn_q;
  assign cs_rise  = csn_q & ~csn_p;
endmodule

// File: rtl/stsreg_bitio.sv
module stsreg_bitio #(
  parameter int unsigned NUM_BYTES = 3,
  parameter int unsigned BYTE_W    = 8,
  localparam int unsigned WIDTH    = NUM_BYTES * BYTE_W,
  localparam int unsigned CNT_W    = $clog2(BYTE_W),
  localparam int unsigned IDX_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_q,
  input  logic              mosi_q,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic [WIDTH-1:0]  cfg_rdsr_ops,
  input  logic [WIDTH-1:0]  commit_next,
  output logic              beat_done,
  output logic              op_done,
  output logic [BYTE_W-1:0] opcode,
  output logic              miso,
  output logic              miso_oe
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              first_q, first_d;
  logic [BYTE_W-1:0] in_q, in_d;
  logic              act_q, act_d;
  logic [IDX_W-1:0]  sel_q, sel_d;
  logic [BYTE_W-1:0] out_q, out_d;
  logic              miso_q, miso_d;
  logic              oe_q, oe_d;

  logic [NUM_BYTES-1:0] hit;
  logic                 hit_any;
  logic [IDX_W-1:0]     hit_idx;
  logic [IDX_W-1:0]     sel_now;
  logic [BYTE_W-1:0]    load_byte;

  assign beat_done = sck_rise && (cnt_q == CNT_W'(BYTE_W - 1));
  assign op_done   = beat_done && first_q;
  assign opcode    = {in_q[BYTE_W-2:0], mosi_q};

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_match
    assign hit[g] = (cfg_rdsr_ops[g*BYTE_W +: BYTE_W] == opcode);
  end

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = NUM_BYTES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  assign sel_now = first_q ? hit_idx : sel_q;

  always_comb begin
    load_byte = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (sel_now == IDX_W'(i)) load_byte = commit_next[i*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    cnt_d   = cnt_q;
    first_d = first_q;
    in_d    = in_q;
    act_d   = act_q;
    sel_d   = sel_q;
    out_d   = out_q;
    miso_d  = miso_q;
    oe_d    = oe_q;
    if (csn_q) begin
      cnt_d   = '0;
      first_d = 1'b1;
      act_d   = 1'b0;
      oe_d    = 1'b0;
    end else begin
      if (sck_rise) begin
        in_d  = opcode;
        cnt_d = beat_done ? '0 : cnt_q + 1'b1;
      end
      if (op_done) begin
        first_d = 1'b0;
        if (hit_any) begin
          act_d = 1'b1;
          sel_d = hit_idx;
        end
      end
      if (beat_done && (act_q || (first_q && hit_any))) begin
        out_d = load_byte;
      end
      if (sck_fall && act_q) begin
        miso_d = out_q[BYTE_W-1];
        out_d  = {out_q[BYTE_W-2:0], 1'b0};
        oe_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
      in_q    <= '0;
      act_q   <= 1'b0;
      sel_q   <= '0;
      out_q   <= '0;
      miso_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      first_q <= first_d;
      in_q    <= in_d;
      act_q   <= act_d;
      sel_q   <= sel_d;
      out_q   <= out_d;
      miso_q  <= miso_d;
      oe_q    <= oe_d;
    end
  end

  assign miso    = miso_q;
  assign miso_oe = oe_q;
endmodule

// File: rtl/stsreg_store.sv
module stsreg_store #(
  parameter int unsigned NUM_BYTES = 3,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned BUSY_POS  = 0,
  parameter int unsigned WEL_POS   = 1,
  localparam int unsigned WIDTH    = NUM_BYTES * BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_valid,
  input  logic [WIDTH-1:0] sw_data,
  input  logic             busy_set,
  input  logic             wren_hit,
  input  logic             wrdi_hit,
  input  logic             commit,
  input  logic             cs_rise,
  output logic [WIDTH-1:0] staged,
  output logic [WIDTH-1:0] commit_next,
  output logic [WIDTH-1:0] committed,
  output logic             gate
);
  logic [WIDTH-1:0] stg_q, stg_d;
  logic [WIDTH-1:0] com_q, com_d;
  logic             win_q, win_d;
  logic             gate_q, gate_d;

  always_comb begin
    stg_d = stg_q;
    if (sw_valid) begin
      stg_d           = sw_data;
      stg_d[BUSY_POS] = stg_q[BUSY_POS] & sw_data[BUSY_POS];
      stg_d[WEL_POS]  = stg_q[WEL_POS] & sw_data[WEL_POS];
    end
    if (wren_hit) begin
      stg_d[WEL_POS] = 1'b1;
    end else if (wrdi_hit) begin
      stg_d[WEL_POS] = 1'b0;
    end
    if (busy_set || win_q) begin
      stg_d[BUSY_POS] = 1'b1;
    end
    win_d  = commit ? 1'b0 : (win_q | busy_set);
    com_d  = commit ? stg_d : com_q;
    gate_d = cs_rise ? stg_d[BUSY_POS] : gate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      com_q  <= '0;
      win_q  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      stg_q  <= stg_d;
      com_q  <= com_d;
      win_q  <= win_d;
      gate_q <= gate_d;
    end
  end

  assign staged      = stg_q;
  assign commit_next = com_d;
  assign committed   = com_q;
  assign gate        = gate_q;
endmodule

// File: rtl/stsreg_emu.sv
module stsreg_emu
  import stsreg_pkg::*;
#(
  parameter int unsigned NUM_BYTES = STS_BYTES,
  parameter int unsigned BYTE_W    = STS_BYTE_W,
  parameter int unsigned BUSY_POS  = BUSY_BIT,
  parameter int unsigned WEL_POS   = WEL_BIT,
  localparam int unsigned WIDTH    = NUM_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic [WIDTH-1:0]  cfg_rdsr_ops,
  input  logic [BYTE_W-1:0] cfg_wren_op,
  input  logic [BYTE_W-1:0] cfg_wrdi_op,
  input  logic              upload_busy,
  input  logic              sw_wr_valid,
  input  logic [WIDTH-1:0]  sw_wr_data,
  output logic [WIDTH-1:0]  status_committed,
  output logic              passthru_block
);
  logic              csn_q, mosi_q, sck_rise, sck_fall, cs_rise;
  logic              beat_done, op_done;
  logic [BYTE_W-1:0] opcode;
  logic              wren_hit, wrdi_hit, commit_w;
  logic [WIDTH-1:0]  staged_w, commit_next_w;

  stsreg_spi_front u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (spi_sck),
    .csn      (spi_csn),
    .mosi     (spi_mosi),
    .csn_q    (csn_q),
    .mosi_q   (mosi_q),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_rise  (cs_rise)
  );

  assign wren_hit = op_done && (opcode == cfg_wren_op);
  assign wrdi_hit = op_done && (opcode == cfg_wrdi_op);
  assign commit_w = beat_done || cs_rise;

  stsreg_store #(
    .NUM_BYTES (NUM_BYTES),
    .BYTE_W    (BYTE_W),
    .BUSY_POS  (BUSY_POS),
    .WEL_POS   (WEL_POS)
  ) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_valid    (sw_wr_valid),
    .sw_data     (sw_wr_data),
    .busy_set    (upload_busy),
    .wren_hit    (wren_hit),
    .wrdi_hit    (wrdi_hit),
    .commit      (commit_w),
    .cs_rise     (cs_rise),
    .staged      (staged_w),
    .commit_next (commit_next_w),
    .committed   (status_committed),
    .gate        (passthru_block)
  );

  stsreg_bitio #(
    .NUM_BYTES (NUM_BYTES),
    .BYTE_W    (BYTE_W)
  ) u_bitio (
    .clk          (clk),
    .rst_n        (rst_n),
    .csn_q        (csn_q),
    .mosi_q       (mosi_q),
    .sck_rise     (sck_rise),
    .sck_fall     (sck_fall),
    .cfg_rdsr_ops (cfg_rdsr_ops),
    .commit_next  (commit_next_w),
    .beat_done    (beat_done),
    .op_done      (op_done),
    .opcode       (opcode),
    .miso         (spi_miso),
    .miso_oe      (spi_miso_oe)
  );
endmodule

// File: rtl/stsreg_emu_chk.sv
module stsreg_emu_chk #(
  parameter int unsigned WIDTH    = 24,
  parameter int unsigned BUSY_POS = 0,
  parameter int unsigned WEL_POS  = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             csn_q,
  input logic             commit,
  input logic             cs_rise,
  input logic             sw_valid,
  input logic             wren_hit,
  input logic             busy_set,
  input logic [WIDTH-1:0] staged,
  input logic [WIDTH-1:0] committed,
  input logic             gate,
  input logic             miso_oe
);
  p_commit_points_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(committed));

  p_gate_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(gate));

  p_gate_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (gate == committed[BUSY_POS]));

  p_busy_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_set |=> staged[BUSY_POS]);

  p_wel_no_sw_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_valid && !wren_hit && !staged[WEL_POS]) |=> !staged[WEL_POS]);

  p_wren_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wren_hit |=> staged[WEL_POS]);

  p_oe_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    csn_q |=> !miso_oe);
endmodule

bind stsreg_emu stsreg_emu_chk #(
  .WIDTH    (WIDTH),
  .BUSY_POS (BUSY_POS),
  .WEL_POS  (WEL_POS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .csn_q     (csn_q),
  .commit    (commit_w),
  .cs_rise   (cs_rise),
  .sw_valid  (sw_wr_valid),
  .wren_hit  (wren_hit),
  .busy_set  (upload_busy),
  .staged    (staged_w),
  .committed (status_committed),
  .gate      (passthru_block),
  .miso_oe   (spi_miso_oe)
);

// File: tb/tb_stsreg_emu.sv
module tb_stsreg_emu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sck = 1'b0;
  logic        spi_csn = 1'b1;
  logic        spi_mosi = 1'b0;
  logic        spi_miso, spi_miso_oe;
  logic [23:0] cfg_rdsr_ops = 24'h15_35_05;
  logic [7:0]  cfg_wren_op = 8'h06;
  logic [7:0]  cfg_wrdi_op = 8'h04;
  logic        upload_busy = 1'b0;
  logic        sw_wr_valid = 1'b0;
  logic [23:0] sw_wr_data = '0;
  logic [23:0] status_committed;
  logic        passthru_block;

  int checks = 0;
  int fails  = 0;
  logic [7:0] rx [0:7];
  logic       oe_early;
  logic       oe_ok;

  always #2.5 clk = ~clk;

  stsreg_emu dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .spi_sck          (spi_sck),
    .spi_csn          (spi_csn),
    .spi_mosi         (spi_mosi),
    .spi_miso         (spi_miso),
    .spi_miso_oe      (spi_miso_oe),
    .cfg_rdsr_ops     (cfg_rdsr_ops),
    .cfg_wren_op      (cfg_wren_op),
    .cfg_wrdi_op      (cfg_wrdi_op),
    .upload_busy      (upload_busy),
    .sw_wr_valid      (sw_wr_valid),
    .sw_wr_data       (sw_wr_data),
    .status_committed (status_committed),
    .passthru_block   (passthru_block)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sw_write(input logic [23:0] d);
    sw_wr_data  = d;
    sw_wr_valid = 1'b1;
    tick(1);
    sw_wr_valid = 1'b0;
    tick(2);
  endtask

  task automatic busy_pulse();
    upload_busy = 1'b1;
    tick(1);
    upload_busy = 1'b0;
    tick(2);
  endtask

  // kind: 0 none, 1 software write, 2 busy strobe; injected at start of data byte inj
  task automatic xfer(input logic [7:0] op, input int nbytes, input int inj,
                      input int kind, input logic [23:0] d);
    oe_early = 1'b0;
    oe_ok    = 1'b1;
    spi_csn  = 1'b0;
    tick(2);
    for (int b = 7; b >= 0; b--) begin
      spi_mosi = op[b];
      spi_sck  = 1'b0;
      tick(4);
      if (spi_miso_oe) oe_early = 1'b1;
      spi_sck = 1'b1;
      tick(4);
    end
    for (int k = 0; k < nbytes; k++) begin
      for (int b = 7; b >= 0; b--) begin
        spi_sck  = 1'b0;
        spi_mosi = 1'b0;
        if (b == 7 && k == inj && kind == 1) begin
          sw_wr_data = d; sw_wr_valid = 1'b1; tick(1); sw_wr_valid = 1'b0; tick(3);
        end else if (b == 7 && k == inj && kind == 2) begin
          upload_busy = 1'b1; tick(1); upload_busy = 1'b0; tick(3);
        end else begin
          tick(4);
        end
        rx[k][b] = spi_miso;
        if (!spi_miso_oe) oe_ok = 1'b0;
        spi_sck = 1'b1;
        tick(4);
      end
    end
    spi_sck = 1'b0;
    tick(4);
    spi_csn = 1'b1;
    tick(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(3);
    // R1 reset state
    chk("R1 status", {8'h0, status_committed}, 32'h0);
    chk("R1 oe", {31'h0, spi_miso_oe}, 32'h0);
    chk("R1 gate", {31'h0, passthru_block}, 32'h0);

    // R4 staged write not visible before commit; R5 BUSY/WEL not settable
    sw_write(24'h3C_5A_FF);
    tick(10);
    chk("R4 no commit yet", {8'h0, status_committed}, 32'h0);
    xfer(8'h9F, 1, -1, 0, '0);
    chk("R9 no oe for foreign opcode", {30'h0, oe_early, oe_ok}, 32'h0);
    chk("R5 write commit", {8'h0, status_committed}, 32'h3C5AFC);
    chk("R9 status kept over CS", {8'h0, status_committed}, 32'h3C5AFC);

    // R2 and R3: sweep every readout slot over two bytes
    for (int i = 0; i < 3; i++) begin
      logic [23:0] v;
      v = 24'h3C5AFC;
      xfer(cfg_rdsr_ops[i*8 +: 8], 2, -1, 0, '0);
      chk("R2 slot byte0", {24'h0, rx[0]}, {24'h0, v[i*8 +: 8]});
      chk("R3 slot repeat", {24'h0, rx[1]}, {24'h0, v[i*8 +: 8]});
      chk("R2 oe", {31'h0, oe_ok}, 32'h1);
    end

    // R7 WEL through opcodes, R5 software may only clear it
    xfer(8'h06, 0, -1, 0, '0);
    chk("R7 wren sets WEL", {8'h0, status_committed}, 32'h3C5AFE);
    sw_write(24'h3C_5A_FF);
    xfer(8'h00, 0, -1, 0, '0);
    chk("R5 write 1 keeps WEL, no BUSY", {8'h0, status_committed}, 32'h3C5AFE);
    sw_write(24'h3C_5A_FD);
    xfer(8'h00, 0, -1, 0, '0);
    chk("R5 sw clears WEL", {8'h0, status_committed}, 32'h3C5AFC);
    xfer(8'h06, 0, -1, 0, '0);
    xfer(8'h04, 0, -1, 0, '0);
    chk("R7 wrdi clears WEL", {8'h0, status_committed}, 32'h3C5AFC);

    // R6 busy strobe, R8 gate at CS release
    busy_pulse();
    tick(6);
    chk("R4 busy not committed idle", {8'h0, status_committed}, 32'h3C5AFC);
    chk("R8 gate not yet", {31'h0, passthru_block}, 32'h0);
    xfer(8'h05, 2, -1, 0, '0);
    chk("R6 busy read back", {24'h0, rx[0]}, 32'hFD);
    chk("R8 gate follows busy", {31'h0, passthru_block}, 32'h1);

    // R3/R4 polling: software clears BUSY mid transaction
    xfer(8'h05, 4, 1, 1, 24'h3C_5A_FC);
    chk("R3 poll byte0", {24'h0, rx[0]}, 32'hFD);
    chk("R4 poll byte1 old", {24'h0, rx[1]}, 32'hFD);
    chk("R4 poll byte2 new", {24'h0, rx[2]}, 32'hFC);
    chk("R3 poll byte3", {24'h0, rx[3]}, 32'hFC);
    chk("R8 gate released", {31'h0, passthru_block}, 32'h0);

    // R6 busy strobe mid transaction becomes visible one byte later
    xfer(8'h05, 3, 0, 2, '0);
    chk("R6 poll before", {24'h0, rx[0]}, 32'hFC);
    chk("R6 poll after", {24'h0, rx[1]}, 32'hFD);
    chk("R8 gate set", {31'h0, passthru_block}, 32'h1);
    sw_write(24'h3C_5A_FC);
    xfer(8'h00, 0, -1, 0, '0);

    // R6 hardware set wins over software clear in the same window
    busy_pulse();
    sw_write(24'h3C_5A_FC);
    xfer(8'h00, 0, -1, 0, '0);
    chk("R6 hw set wins", {8'h0, status_committed}, 32'h3C5AFD);
    sw_write(24'h3C_5A_FC);
    xfer(8'h00, 0, -1, 0, '0);
    chk("R6 later clear", {8'h0, status_committed}, 32'h3C5AFC);
    chk("R8 gate clear", {31'h0, passthru_block}, 32'h0);

    // R2 duplicate opcode: lowest slot wins
    cfg_rdsr_ops = 24'h15_05_05;
    xfer(8'h05, 1, -1, 0, '0);
    chk("R2 duplicate lowest slot", {24'h0, rx[0]}, 32'hFC);
    cfg_rdsr_ops = 24'h15_35_05;

    // second pattern sweep
    sw_write(24'h81_7E_F3);
    xfer(8'h00, 0, -1, 0, '0);
    chk("R5 pattern2", {8'h0, status_committed}, 32'h817EF0);
    for (int i = 0; i < 3; i++) begin
      logic [23:0] v;
      v = 24'h817EF0;
      xfer(cfg_rdsr_ops[i*8 +: 8], 1, -1, 0, '0);
      chk("R2 pattern2 slot", {24'h0, rx[0]}, {24'h0, v[i*8 +: 8]});
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule